// File: doc/BRIEF.md
# Serial Port Control-Word Sequencer

This block sits on the CPU side of a programmable serial port and decides what each control write means. A select input tells control writes apart from data writes. The block gives a control write a meaning from its position in a fixed sequence. After reset, the first control write configures the line format and is called the mode word. In synchronous mode, the next one or two control writes are stored as SYNC characters. Every control write after that is a command. Data writes belong to the serializers, which are outside this block, and the sequencer ignores them.

The block holds the stored mode word, both SYNC characters and the last command. From these it decodes the line-format fields and drives the modem handshake outputs and transmit enable. It also drives two single-cycle pulses: one that clears error flags and one that signals an internal reset. A command with its internal-reset bit set returns every register to its reset value, and the sequencer then waits for a new mode word. A status byte combines the data-set-ready input, the transmit enable and the current sequencer position.

Top module: `sercfg_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, these outputs hold the following values: `rts_n`=1, `dtr_n`=1, `tx_en`=0, `err_clr`=0, `int_rst`=0, all mode fields 0, both SYNC characters 0, and the status position bits [1:0]=00, which mean the sequencer is waiting for a mode word.
- R2: The first control write (`wr_en`=1, `ctl_sel`=1) after reset is stored as the mode word. One cycle later the outputs decode it as follows: `clk_factor`=bits 1:0, `char_len`=bits 3:2, `par_en`=bit 4 and `par_even`=bit 5.
- R3: A mode word with bits 1:0 = 00 selects synchronous mode. In that case `sync_mode`=1, `ext_sync`=bit 6, `single_sync`=bit 7 and `stop_sel`=0. The next control write is stored in `sync_char1`. When `single_sync`=1, the control writes after that are commands.
- R4: In synchronous mode with `single_sync`=0, the control write after the first SYNC character is stored in `sync_char2`. The control writes after that are commands.
- R5: A mode word with bits 1:0 not equal to 00 selects asynchronous mode. In that case `sync_mode`=0, `stop_sel`=bits 7:6, `ext_sync`=0 and `single_sync`=0. The next control write is a command.
- R6: One cycle after a command write without bit 6, the outputs follow the command: `tx_en`=bit 0, `dtr_n`=NOT bit 1 and `rts_n`=NOT bit 5.
- R7: A command write with bit 4 set drives `err_clr` high for exactly the next cycle. This also holds when bit 6 is set in the same command.
- R8: A command write with bit 6 set drives `int_rst` high for the next cycle. On that cycle every register is back at its R1 value and the position bits are 00. The control write after that is taken as a new mode word.
- R9: Data writes (`ctl_sel`=0) and cycles with `wr_en`=0 leave all outputs unchanged, apart from the `dsr_n`-driven status bit.
- R10: The status byte is built as follows: bit 7 = NOT `dsr_n` (a high `dsr_n` reads as 0), bit 2 = `tx_en`, and bits 1:0 give the position (00 mode, 01 first SYNC, 10 second SYNC, 11 command). Bits 6:3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one cycle per write |
| ctl_sel | input | 1 | 1 = control write, 0 = data write |
| wr_data | input | 8 | Write data byte |
| dsr_n | input | 1 | Data-set-ready, active low |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| tx_en | output | 1 | Transmit enable |
| err_clr | output | 1 | Single-cycle error-clear pulse |
| int_rst | output | 1 | Single-cycle internal-reset pulse |
| sync_mode | output | 1 | Synchronous mode selected |
| clk_factor | output | 2 | Mode bits 1:0 |
| char_len | output | 2 | Character length code |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity select |
| ext_sync | output | 1 | External sync detect (synchronous mode only) |
| single_sync | output | 1 | Single SYNC character (synchronous mode only) |
| stop_sel | output | 2 | Stop-bit code (asynchronous mode only) |
| sync_char1 | output | 8 | First SYNC character |
| sync_char2 | output | 8 | Second SYNC character |
| status | output | 8 | Status byte |

## Verification
A single command can carry both the error-clear bit and the internal-reset bit, so two actions fall on the same clock edge. On that edge the pulse must fire while the command register and the mode word are being wiped. The bench writes such a command in both asynchronous and synchronous setups and compares both pulses, the idle handshake outputs and the position bits with its model on the following cycle. It then checks that the next control write is taken as a mode word. Back-to-back control writes with no idle cycle between them also exercise a sequencer step and a register update on the same edge.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

  typedef enum logic [1:0] {
    PH_MODE  = 2'b00,
    PH_SYNC1 = 2'b01,
    PH_SYNC2 = 2'b10,
    PH_CMD   = 2'b11
  } phase_t;

  localparam int CMD_TXEN = 0;
  localparam int CMD_DTR  = 1;
  localparam int CMD_ERR  = 4;
  localparam int CMD_RTS  = 5;
  localparam int CMD_IRST = 6;

  // mode word bits 1:0 equal to zero pick the synchronous format
  function automatic logic mode_is_sync(input logic [7:0] m);
    return (m[1:0] == 2'b00);
  endfunction

  // position that follows a control write in the given position
  function automatic phase_t phase_after(input phase_t p,
                                         input logic [7:0] mode_q,
                                         input logic [7:0] d);
    phase_t n;
    case (p)
      PH_MODE:  n = mode_is_sync(d) ? PH_SYNC1 : PH_CMD;
      PH_SYNC1: n = mode_q[7] ? PH_CMD : PH_SYNC2;
      default:  n = PH_CMD;
    endcase
    return n;
  endfunction

  function automatic logic [1:0] stop_code(input logic [7:0] m);
    return mode_is_sync(m) ? 2'b00 : m[7:6];
  endfunction

endpackage

// File: rtl/sercfg_phase.sv
module sercfg_phase
  import sercfg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] mode_q,
  output phase_t            phase,
  output logic              ev_mode_ld,
  output logic              ev_sync1_ld,
  output logic              ev_sync2_ld,
  output logic              ev_cmd_ld,
  output logic              ev_irst
);

  logic cmd_wr;

  assign ev_mode_ld  = ctl_wr && (phase == PH_MODE);
  assign ev_sync1_ld = ctl_wr && (phase == PH_SYNC1);
  assign ev_sync2_ld = ctl_wr && (phase == PH_SYNC2);
  assign cmd_wr      = ctl_wr && (phase == PH_CMD);
  assign ev_irst     = cmd_wr && wr_data[CMD_IRST];
  assign ev_cmd_ld   = cmd_wr && !wr_data[CMD_IRST];

  always_ff @(posedge clk) begin
    if (rst || ev_irst) phase <= PH_MODE;
    else if (ctl_wr)    phase <= phase_after(phase, mode_q[7:0], wr_data[7:0]);
  end

endmodule

// File: rtl/sercfg_regs.sv
module sercfg_regs
  import sercfg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ev_mode_ld,
  input  logic              ev_sync1_ld,
  input  logic              ev_sync2_ld,
  input  logic              ev_cmd_ld,
  input  logic              ev_irst,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] sync1_q,
  output logic [DATA_W-1:0] sync2_q,
  output logic [DATA_W-1:0] cmd_q,
  output logic              err_pulse,
  output logic              irst_pulse
);

  logic wipe;
  assign wipe = rst || ev_irst;

  always_ff @(posedge clk) begin
    if (wipe) begin
      mode_q  <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
      cmd_q   <= '0;
    end else begin
      if (ev_mode_ld)  mode_q  <= wr_data;
      if (ev_sync1_ld) sync1_q <= wr_data;
      if (ev_sync2_ld) sync2_q <= wr_data;
      if (ev_cmd_ld)   cmd_q   <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_pulse  <= 1'b0;
      irst_pulse <= 1'b0;
    end else begin
      err_pulse  <= (ev_cmd_ld || ev_irst) && wr_data[CMD_ERR];
      irst_pulse <= ev_irst;
    end
  end

endmodule

// File: rtl/sercfg_status.sv
module sercfg_status
  import sercfg_pkg::*;
(
  input  logic       dsr_n,
  input  logic       tx_en,
  input  phase_t     phase,
  output logic [7:0] status
);

  always_comb begin
    status      = '0;
    status[7]   = !dsr_n;
    status[2]   = tx_en;
    status[1:0] = phase;
  end

endmodule

// File: rtl/sercfg_seq.sv
module sercfg_seq
  import sercfg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              ctl_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dsr_n,
  output logic              rts_n,
  output logic              dtr_n,
  output logic              tx_en,
  output logic              err_clr,
  output logic              int_rst,
  output logic              sync_mode,
  output logic [1:0]        clk_factor,
  output logic [1:0]        char_len,
  output logic              par_en,
  output logic              par_even,
  output logic              ext_sync,
  output logic              single_sync,
  output logic [1:0]        stop_sel,
  output logic [DATA_W-1:0] sync_char1,
  output logic [DATA_W-1:0] sync_char2,
  output logic [7:0]        status
);

  phase_t            phase;
  logic              ctl_wr;
  logic              ev_mode_ld, ev_sync1_ld, ev_sync2_ld, ev_cmd_ld, ev_irst;
  logic [DATA_W-1:0] mode_q, cmd_q;
  logic              configured;

  assign ctl_wr = wr_en && ctl_sel;

  sercfg_phase #(.DATA_W(DATA_W)) u_phase (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .wr_data(wr_data), .mode_q(mode_q),
    .phase(phase), .ev_mode_ld(ev_mode_ld), .ev_sync1_ld(ev_sync1_ld),
    .ev_sync2_ld(ev_sync2_ld), .ev_cmd_ld(ev_cmd_ld), .ev_irst(ev_irst)
  );

  sercfg_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_data(wr_data),
    .ev_mode_ld(ev_mode_ld), .ev_sync1_ld(ev_sync1_ld), .ev_sync2_ld(ev_sync2_ld),
    .ev_cmd_ld(ev_cmd_ld), .ev_irst(ev_irst),
    .mode_q(mode_q), .sync1_q(sync_char1), .sync2_q(sync_char2), .cmd_q(cmd_q),
    .err_pulse(err_clr), .irst_pulse(int_rst)
  );

  assign configured  = (phase != PH_MODE);
  assign sync_mode   = configured && mode_is_sync(mode_q[7:0]);
  assign clk_factor  = mode_q[1:0];
  assign char_len    = mode_q[3:2];
  assign par_en      = mode_q[4];
  assign par_even    = mode_q[5];
  assign ext_sync    = sync_mode && mode_q[6];
  assign single_sync = sync_mode && mode_q[7];
  assign stop_sel    = stop_code(mode_q[7:0]);

  assign tx_en = cmd_q[CMD_TXEN];
  assign dtr_n = !cmd_q[CMD_DTR];
  assign rts_n = !cmd_q[CMD_RTS];

  sercfg_status u_status (
    .dsr_n(dsr_n), .tx_en(tx_en), .phase(phase), .status(status)
  );

endmodule

// File: rtl/sercfg_chk.sv
module sercfg_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              ctl_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              dsr_n,
  input logic              rts_n,
  input logic              dtr_n,
  input logic              tx_en,
  input logic              err_clr,
  input logic              int_rst,
  input logic [7:0]        status
);

  // R6: a plain command sets transmit enable from bit 0
  a_r6_cmd_txen: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ctl_sel && status[1:0] == 2'b11 && !wr_data[6]) |=> (tx_en == $past(wr_data[0])));

  // R7: error clear only follows a command write with bit 4
  a_r7_err_src: assert property (@(posedge clk) disable iff (rst)
    err_clr |-> ($past(wr_en && ctl_sel && wr_data[4]) && $past(status[1:0]) == 2'b11));

  // R8: internal reset leaves handshake idle and sequencer at mode
  a_r8_irst_idle: assert property (@(posedge clk) disable iff (rst)
    int_rst |-> (!tx_en && rts_n && dtr_n && status[1:0] == 2'b00));

  // R9: no control write keeps the handshake outputs
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && ctl_sel) |=> ($stable(tx_en) && $stable(rts_n) && $stable(dtr_n) && !int_rst && !err_clr));

  // R10: status bit 7 follows inverted data-set-ready
  a_r10_dsr: assert property (@(posedge clk) disable iff (rst)
    status[7] == !dsr_n);

endmodule

bind sercfg_seq sercfg_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sercfg_seq_tb.sv
module sercfg_seq_tb;
  localparam int PERIOD = 10;

  logic clk = 0, rst = 1, wr_en = 0, ctl_sel = 0, dsr_n = 1;
  logic [7:0] wr_data = '0;
  logic rts_n, dtr_n, tx_en, err_clr, int_rst, sync_mode, par_en, par_even, ext_sync, single_sync;
  logic [1:0] clk_factor, char_len, stop_sel;
  logic [7:0] sync_char1, sync_char2, status;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  int m_ph = 0, m_err = 0, m_irst = 0;
  logic [7:0] m_mode = 0, m_s1 = 0, m_s2 = 0, m_cmd = 0;

  always #(PERIOD/2) clk = ~clk;

  sercfg_seq u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .ctl_sel(ctl_sel), .wr_data(wr_data), .dsr_n(dsr_n),
    .rts_n(rts_n), .dtr_n(dtr_n), .tx_en(tx_en), .err_clr(err_clr), .int_rst(int_rst),
    .sync_mode(sync_mode), .clk_factor(clk_factor), .char_len(char_len), .par_en(par_en),
    .par_even(par_even), .ext_sync(ext_sync), .single_sync(single_sync), .stop_sel(stop_sel),
    .sync_char1(sync_char1), .sync_char2(sync_char2), .status(status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit sy;
    sy = (m_ph != 0) && (m_mode[1:0] == 0);
    chk("R6 tx_en", tx_en, m_cmd[0]);
    chk("R6 dtr_n", dtr_n, !m_cmd[1]);
    chk("R6 rts_n", rts_n, !m_cmd[5]);
    chk("R7 err_clr", err_clr, m_err);
    chk("R8 int_rst", int_rst, m_irst);
    chk("R2 clk_factor", clk_factor, m_mode[1:0]);
    chk("R2 char_len", char_len, m_mode[3:2]);
    chk("R2 par", {par_even, par_en}, {m_mode[5], m_mode[4]});
    chk("R3 sync_mode", sync_mode, sy);
    chk("R3 ext/single", {single_sync, ext_sync}, sy ? {m_mode[7], m_mode[6]} : 0);
    chk("R5 stop_sel", stop_sel, (m_mode[1:0] == 0) ? 0 : m_mode[7:6]);
    chk("R3 sync_char1", sync_char1, m_s1);
    chk("R4 sync_char2", sync_char2, m_s2);
    chk("R10 status", status, {!dsr_n, 4'b0, m_cmd[0], 2'(m_ph)});
  endtask

  task automatic model_step();
    m_err = 0; m_irst = 0;
    if (rst) begin
      m_ph = 0; m_mode = 0; m_s1 = 0; m_s2 = 0; m_cmd = 0;
    end else if (wr_en && ctl_sel) begin
      case (m_ph)
        0: begin m_mode = wr_data; m_ph = (wr_data[1:0] == 0) ? 1 : 3; end
        1: begin m_s1 = wr_data; m_ph = m_mode[7] ? 3 : 2; end
        2: begin m_s2 = wr_data; m_ph = 3; end
        default: begin
          m_err = wr_data[4];
          if (wr_data[6]) begin
            m_irst = 1; m_ph = 0; m_mode = 0; m_s1 = 0; m_s2 = 0; m_cmd = 0;
          end else m_cmd = wr_data;
        end
      endcase
    end
  endtask

  // one cycle: compare current outputs, drive next inputs, advance model
  task automatic cyc(input bit r, input bit w, input bit c, input logic [7:0] d, input bit dn);
    @(negedge clk);
    compare_all();
    rst = r; wr_en = w; ctl_sel = c; wr_data = d; dsr_n = dn;
    model_step();
  endtask

  task automatic ctl(input logic [7:0] d); cyc(0, 1, 1, d, dsr_n); endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 8'h00, dsr_n);
  endtask

  initial begin
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 8'h00, 1);
    idle(1);
    @(negedge clk);
    // R1 explicit idle values
    chk("R1 rts_n", rts_n, 1); chk("R1 dtr_n", dtr_n, 1); chk("R1 tx_en", tx_en, 0);
    chk("R1 pulses", {err_clr, int_rst}, 0); chk("R1 status pos", status[1:0], 0);
    chk("R1 sync_mode", sync_mode, 0);
    // asynchronous: 16x, 8 bits, 2 stop
    ctl(8'hCE);
    cyc(0, 1, 0, 8'h55, 1);                 // R9 data write ignored
    cyc(0, 1, 0, 8'hFF, 0);
    ctl(8'h23);                             // R6
    idle(2);
    @(negedge clk);
    chk("R6 tx_en on", tx_en, 1); chk("R6 rts low", rts_n, 0);
    cyc(0, 1, 0, 8'h00, 1);                 // R9 data write
    @(negedge clk);
    chk("R9 hold tx_en", tx_en, 1); chk("R9 hold dtr", dtr_n, 0);
    ctl(8'h10);                             // R7 error clear only
    ctl(8'h01);
    ctl(8'h50);                             // R7+R8 same edge
    idle(1);
    // synchronous, double SYNC, internal detect, parity even
    ctl(8'h3C);
    cyc(0, 1, 0, 8'hAA, 0);
    ctl(8'h16);
    idle(1);
    ctl(8'h17);                             // R4
    ctl(8'h27);
    idle(2);
    ctl(8'h52);                             // R7+R8 again
    // synchronous, single SYNC, external detect
    ctl(8'hC0);
    ctl(8'h7E);                             // R3
    ctl(8'h02);
    idle(1);
    // hardware reset mid-stream then asynchronous 1x, 1 stop
    cyc(1, 1, 1, 8'h33, 1);
    cyc(1, 0, 0, 8'h00, 1);
    idle(1);
    ctl(8'h41);                             // R5
    ctl(8'h21);
    cyc(0, 1, 0, 8'h40, 0);                 // R9: data with reset bit ignored
    idle(3);
    ctl(8'h40);                             // R8
    ctl(8'h0F);                             // taken as new mode
    ctl(8'h25);
    idle(3);
    @(negedge clk);
    compare_all();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule